// File: doc/BRIEF.md
# Go/Done Adapter for a Self-Wrapping Fixed-Latency Counter

This block lets a fixed-latency schedule, driven by a counter that returns to its first state on its own after the last cycle, take part in a variable-latency go/done handshake. While its caller holds `go`, the adapter drives the schedule's start strobe `inner_go`. The counter steps through `LATENCY` states and then wraps to zero. The adapter's own completion signal comes from a one-bit sticky flag. Because of that, the counter does not need to pause in an extra "finished" state.

In single-pass mode, the flag is set when the counter sits in its final state with `go` high. The flag reads back as `done` on the following cycle, when the counter is already at state 0. The flag then clears itself on the next edge.

In loop mode (`LOOP_MODE = 1`), the schedule is the body of a loop. The adapter evaluates a stable loop-condition bit whenever the counter is at state 0. A low bit ends the loop in that same cycle, so consecutive iterations run back to back with no check cycle between them.

Top module: `go_done_wrapper`

## Requirements
- R1: After synchronous active-high reset, `state` is 0 and `done` is 0.
- R2: In single-pass mode `inner_go` equals `go` in every cycle; in loop mode `inner_go` equals `go` except in a cycle where `done` is high, when it is 0.
- R3: On each clock edge with `inner_go` high, `state` advances by one, and from `LATENCY-1` it returns to 0; with `inner_go` low `state` holds.
- R4: In single-pass mode, `done` is high in exactly the cycle after an edge that saw `state == LATENCY-1` with `go` high, and `state` reads 0 in that cycle.
- R5: In single-pass mode, `done` never stays high for two consecutive cycles.
- R6: In single-pass mode, an edge where `state == LATENCY-1` but `go` is low does not set `done`, and the counter keeps its state.
- R7: In loop mode, `done` is high in any cycle where `go` is 1, `state` is 0 and `cond` is 0; it is low otherwise.
- R8: In loop mode, while `cond` stays 1 the counter passes from `LATENCY-1` directly to 0 and on to 1 with no idle cycle.
- R9: In loop mode, `state` holds at 0 through the cycles where `done` is high, including a first cycle in which `cond` is already 0 (zero iterations).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Caller's start request, held until `done` |
| cond | input | 1 | Loop-condition bit (loop mode only), stable while sampled |
| done | output | 1 | Completion indication |
| inner_go | output | 1 | Start strobe driven to the fixed-latency schedule |
| state | output | $clog2(LATENCY) | Current counter state |

## Verification
On every cycle, the assertions check counter stepping, wrapping and holding, the rule that `done` only appears at state 0, the one-cycle width of the single-pass `done`, its link to the final state seen one edge earlier, and the loop-mode exit condition. Some behaviours only show in the bench's scenarios because they depend on ordered sequences. These are a caller pausing `go` mid-run and resuming, `go` dropping exactly at the final state, several back-to-back loop iterations crossing the wrap, a held `done` while the caller keeps `go` high, and a loop entered with its condition already false.

// File: rtl/go_done_wrapper.sv
module go_done_wrapper #(
  parameter int LATENCY   = 4,
  parameter bit LOOP_MODE = 1'b0,
  localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          cond,
  output logic          done,
  output logic          inner_go,
  output logic [CW-1:0] state
);
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

  logic at_last;
  assign at_last = (state == LAST);

  always_ff @(posedge clk) begin
    if (rst)           state <= '0;
    else if (inner_go) state <= at_last ? '0 : state + 1'b1;
  end

  generate
    if (LOOP_MODE) begin : g_loop
      assign done     = go && (state == '0) && !cond;
      assign inner_go = go && !done;
    end else begin : g_single
      logic fin_q;
      always_ff @(posedge clk) begin
        if (rst)                      fin_q <= 1'b0;
        else if (fin_q)               fin_q <= 1'b0;
        else if (go && at_last)       fin_q <= 1'b1;
      end
      assign done     = fin_q;
      assign inner_go = go;
    end
  endgenerate
endmodule

module go_done_wrapper_chk #(
  parameter int LATENCY   = 4,
  parameter bit LOOP_MODE = 1'b0,
  parameter int CW        = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic          cond,
  input logic          done,
  input logic          inner_go,
  input logic [CW-1:0] state
);
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (inner_go && state == CW'(LATENCY - 1)) |=> state == '0);
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (inner_go && state != CW'(LATENCY - 1)) |=> state == $past(state) + 1'b1);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !inner_go |=> $stable(state));
  a_r4_done_at_zero: assert property (@(posedge clk) disable iff (rst)
    done |-> state == '0);
  a_r4_done_cause: assert property (@(posedge clk) disable iff (rst)
    (!LOOP_MODE && done) |-> ($past(state) == CW'(LATENCY - 1) && $past(go)));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (!LOOP_MODE && done) |=> !done);
  a_r7_loop_exit: assert property (@(posedge clk) disable iff (rst)
    LOOP_MODE |-> (done == (go && state == '0 && !cond)));
endmodule

bind go_done_wrapper go_done_wrapper_chk #(
  .LATENCY(LATENCY), .LOOP_MODE(LOOP_MODE), .CW(CW)
) u_chk (.*);

// File: tb/go_done_wrapper_bench.sv
module go_done_wrapper_bench;
  localparam int L = 4;
  logic clk = 0, rst = 1;
  logic go_s = 0, go_l = 0, cond_l = 0;
  logic done_s, ig_s, done_l, ig_l;
  logic [1:0] st_s, st_l;
  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  go_done_wrapper #(.LATENCY(L), .LOOP_MODE(1'b0)) u_go_done_wrapper (
    .clk(clk), .rst(rst), .go(go_s), .cond(1'b0),
    .done(done_s), .inner_go(ig_s), .state(st_s));
  go_done_wrapper #(.LATENCY(L), .LOOP_MODE(1'b1)) u_go_done_wrapper_loop (
    .clk(clk), .rst(rst), .go(go_l), .cond(cond_l),
    .done(done_l), .inner_go(ig_l), .state(st_l));

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1; go_s = 0; go_l = 0; cond_l = 0;
    tick(); tick(); rst = 0; #1;
    chk("R1 state", st_s, 0); chk("R1 done", done_s, 0);
    chk("R1 loop state", st_l, 0);
  endtask

  task automatic t_single_run();
    go_s = 1; #1;
    chk("R2 inner_go follows go", ig_s, 1);
    for (int k = 1; k < L; k++) begin
      tick();
      chk("R3 step", st_s, k); chk("R4 no early done", done_s, 0);
    end
    tick();
    chk("R4 done after last", done_s, 1); chk("R4 state zero", st_s, 0);
    go_s = 0; #1;
    chk("R2 inner_go low", ig_s, 0);
    tick();
    chk("R5 done one cycle", done_s, 0); chk("R3 hold", st_s, 0);
  endtask

  task automatic t_pause();
    go_s = 1; tick(); tick();
    chk("R3 paused run", st_s, 2);
    go_s = 0; tick(); tick();
    chk("R3 hold while paused", st_s, 2); chk("R4 no done", done_s, 0);
    go_s = 1; tick();
    chk("R3 resume", st_s, 3);
    go_s = 0; tick();
    chk("R6 no done without go", done_s, 0); chk("R6 holds last", st_s, 3);
    tick();
    chk("R6 still no done", done_s, 0);
    go_s = 1; tick();
    chk("R4 done after resume", done_s, 1); chk("R3 wrap", st_s, 0);
    go_s = 0; tick();
    chk("R5 cleared", done_s, 0);
  endtask

  task automatic t_loop();
    cond_l = 1; go_l = 1; #1;
    chk("R7 no done while cond", done_l, 0); chk("R2 loop inner_go", ig_l, 1);
    for (int k = 1; k <= 2 * L + 1; k++) begin
      tick();
      chk("R8 back-to-back", st_l, k % L);
      chk("R7 no exit", done_l, 0);
    end
    cond_l = 0;
    for (int k = 2; k < L; k++) tick();
    chk("R7 no exit off state 0", done_l, 0);
    tick();
    chk("R7 exit at state 0", done_l, 1); chk("R2 inner_go off on done", ig_l, 0);
    tick();
    chk("R9 held at 0", st_l, 0); chk("R7 done held", done_l, 1);
    go_l = 0; #1;
    chk("R7 done needs go", done_l, 0);
    tick();
    go_l = 1; #1;
    chk("R9 zero-iteration done", done_l, 1);
    tick();
    chk("R9 no advance", st_l, 0);
    go_l = 0; tick();
  endtask

  initial begin
    fork
      begin
        t_reset(); t_single_run(); t_pause(); t_loop();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule